// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a small reversible counter with two separate count inputs: one steps it up, the other steps it down. A free-running system clock samples every input. A count happens when a rising edge is seen on one count input while the other count input is held high. Each stage also has a parallel preset, taken from the data inputs while the active-low preset is asserted, and an active-high zero input that overrides everything else.

Two active-low outputs, overflow and underflow, are meant for chaining. The overflow output goes low while the stage is at its top value and its up input is low. The underflow output goes low while the stage is at zero and its down input is low. Each of these pulses therefore lasts as long as the count pulse that causes the wrap. To chain stages, connect overflow to the next stage's up input and underflow to its down input, with no extra logic between them. A parameter selects binary counting (0 to 2^WIDTH-1) or decade counting (0 to 9).

All inputs first pass through a synchronizer of SYNC_STAGES flops. Counts, presets and clears all take effect on the same path, so their relative order at the pins is kept.

Top module: `bidir_preset_counter`

## Requirements
- R1: After system reset, count is 0 and both ovf_n and unf_n are 1.
- R2: A rising edge on inc_in while dec_in is high adds one to the count. In binary mode the top value wraps to 0.
- R3: A rising edge on dec_in while inc_in is high subtracts one from the count. Zero wraps to the top value (15 in binary mode, 9 in decade mode).
- R4: If rising edges on inc_in and dec_in are seen in the same sampling cycle, the count holds.
- R5: While preset_n is low, count follows pdata, and count edges arriving during that time have no effect.
- R6: While zero_in is high, count is forced to 0, whatever preset_n and the count inputs do.
- R7: ovf_n is low only while count equals the top value and the synchronized inc_in is low.
- R8: unf_n is low only while count is 0 and the synchronized dec_in is low.
- R9: With DECADE=1, counting up from 9 gives 0, counting up from any preset value above 9 gives 0, and counting down from a value above 9 subtracts one.
- R10: Two binary stages chained through ovf_n and unf_n count together as one 8-bit counter.
- R11: All count bits change together, on one system clock edge, SYNC_STAGES+1 cycles after the input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| inc_in | input | 1 | Up-count input; counts on its rising edge |
| dec_in | input | 1 | Down-count input; counts on its rising edge |
| preset_n | input | 1 | Active-low parallel preset |
| zero_in | input | 1 | Active-high clear, highest priority |
| pdata | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| ovf_n | output | 1 | Active-low overflow pulse for chaining |
| unf_n | output | 1 | Active-low underflow pulse for chaining |

## Verification
The assertions assume that the count inputs idle high and that only one of them is pulsed at a time, except for deliberate coincident pulses. They also assume that every input holds steady for at least one sampling cycle, so the synchronizer never drops a level. The bench keeps to these assumptions: it changes inputs only on falling clock edges, makes every pulse several cycles wide, and returns to the idle levels between operations. It then allows enough cycles for a wrap to ripple through the second chained stage before it compares.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_INC  = 2'd1,
    EV_DEC  = 2'd2,
    EV_BOTH = 2'd3
  } cnt_event_e;

  localparam int unsigned DEF_WIDTH = 4;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bpc_edge.sv
module bpc_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else prev_q <= lvl;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rise
      assign rise[i] = lvl[i] & ~prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/bpc_core.sv
module bpc_core
  import bpc_pkg::*;
#(
  parameter int unsigned W = 4,
  parameter bit DECADE = 1'b0,
  parameter logic [W-1:0] TOP_Q = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  input  logic         up_rise,
  input  logic         dn_rise,
  input  logic         up_lvl,
  input  logic         dn_lvl,
  output logic [W-1:0] q
);
  cnt_event_e ev;
  logic [W-1:0] q_inc, q_dec;

  always_comb begin
    ev = EV_HOLD;
    if (up_rise && dn_rise) ev = EV_BOTH;
    else if (up_rise && dn_lvl) ev = EV_INC;
    else if (dn_rise && up_lvl) ev = EV_DEC;
  end

  generate
    if (DECADE) begin : g_dec
      assign q_inc = (q >= TOP_Q) ? '0 : q + 1'b1;
    end else begin : g_bin
      assign q_inc = (q == TOP_Q) ? '0 : q + 1'b1;
    end
  endgenerate

  assign q_dec = (q == '0) ? TOP_Q : q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (clr) q <= '0;
    else if (!ld_n) q <= d;
    else begin
      case (ev)
        EV_INC:  q <= q_inc;
        EV_DEC:  q <= q_dec;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/bpc_flags.sv
module bpc_flags #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TOP_Q = '1
) (
  input  logic [W-1:0] q,
  input  logic         up_lvl,
  input  logic         dn_lvl,
  output logic         ovf_n,
  output logic         unf_n
);
  assign ovf_n = ~((q == TOP_Q) & ~up_lvl);
  assign unf_n = ~((q == '0) & ~dn_lvl);
endmodule

// File: rtl/bidir_preset_counter.sv
module bidir_preset_counter
  import bpc_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  parameter bit          DECADE      = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_in,
  input  logic             dec_in,
  input  logic             preset_n,
  input  logic             zero_in,
  input  logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] count,
  output logic             ovf_n,
  output logic             unf_n
);
  localparam int unsigned SW = WIDTH + 4;
  localparam logic [WIDTH-1:0] TOP_Q = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b1, 1'b0, {WIDTH{1'b0}}};

  logic [SW-1:0] raw_v, syn_v;
  logic up_s, dn_s, ld_s, clr_s;
  logic [WIDTH-1:0] d_s;
  logic [1:0] rise_v;
  logic up_rise, dn_rise;

  assign raw_v = {inc_in, dec_in, preset_n, zero_in, pdata};

  bpc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_v), .dout(syn_v)
  );

  assign {up_s, dn_s, ld_s, clr_s, d_s} = syn_v;

  bpc_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({up_s, dn_s}), .rise(rise_v)
  );

  assign {up_rise, dn_rise} = rise_v;

  bpc_core #(.W(WIDTH), .DECADE(DECADE), .TOP_Q(TOP_Q)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr_s), .ld_n(ld_s), .d(d_s),
    .up_rise(up_rise), .dn_rise(dn_rise), .up_lvl(up_s), .dn_lvl(dn_s),
    .q(count)
  );

  bpc_flags #(.W(WIDTH), .TOP_Q(TOP_Q)) u_flags (
    .q(count), .up_lvl(up_s), .dn_lvl(dn_s), .ovf_n(ovf_n), .unf_n(unf_n)
  );
endmodule

// File: rtl/bpc_chk.sv
module bpc_chk #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TOP_Q = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] q,
  input logic         ovf_n,
  input logic         unf_n,
  input logic         up_s,
  input logic         dn_s,
  input logic         up_rise,
  input logic         dn_rise,
  input logic         clr_s,
  input logic         ld_s,
  input logic [W-1:0] d_s
);
  // R6
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (q == '0));

  // R5
  preset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !ld_s) |=> (q == $past(d_s)));

  // R4
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s && up_rise && dn_rise) |=> $stable(q));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s && up_rise && !dn_rise && dn_s && $past(ld_s) && $past(!clr_s) && q < TOP_Q)
      |=> (q == $past(q) + 1'b1));

  // R3
  dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s && dn_rise && !up_rise && up_s && q != '0) |=> (q == $past(q) - 1'b1));

  // R7
  ovf_when_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_n |-> (q == TOP_Q && !up_s));

  // R8
  unf_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unf_n |-> (q == '0 && !dn_s));

  // R11
  no_idle_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s && !up_rise && !dn_rise) |=> $stable(q));
endmodule

bind bidir_preset_counter bpc_chk #(.W(WIDTH), .TOP_Q(TOP_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .q(count), .ovf_n(ovf_n), .unf_n(unf_n),
  .up_s(up_s), .dn_s(dn_s), .up_rise(up_rise), .dn_rise(dn_rise),
  .clr_s(clr_s), .ld_s(ld_s), .d_s(d_s)
);

// File: tb/bidir_preset_counter_test.sv
module bidir_preset_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc = 1'b1, dec = 1'b1, pre_n = 1'b1, zero = 1'b0;
  logic [3:0] d_lo = '0, d_hi = '0;
  logic [3:0] q_lo, q_hi, q_dec;
  logic ovf_lo, unf_lo, ovf_hi, unf_hi, ovf_dc, unf_dc;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m_pair = '0;
  logic [3:0] m_dec = '0;

  always #4 clk = ~clk;

  bidir_preset_counter #(.WIDTH(4), .DECADE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .inc_in(inc), .dec_in(dec), .preset_n(pre_n),
    .zero_in(zero), .pdata(d_lo), .count(q_lo), .ovf_n(ovf_lo), .unf_n(unf_lo));

  bidir_preset_counter #(.WIDTH(4), .DECADE(1'b0)) uut_hi (
    .clk(clk), .rst_n(rst_n), .inc_in(ovf_lo), .dec_in(unf_lo), .preset_n(pre_n),
    .zero_in(zero), .pdata(d_hi), .count(q_hi), .ovf_n(ovf_hi), .unf_n(unf_hi));

  bidir_preset_counter #(.WIDTH(4), .DECADE(1'b1)) uut_dec (
    .clk(clk), .rst_n(rst_n), .inc_in(inc), .dec_in(dec), .preset_n(pre_n),
    .zero_in(zero), .pdata(d_lo), .count(q_dec), .ovf_n(ovf_dc), .unf_n(unf_dc));

  function automatic logic [3:0] dec_up(logic [3:0] v);
    return (v >= 4'd9) ? 4'd0 : v + 4'd1;
  endfunction

  function automatic logic [3:0] dec_dn(logic [3:0] v);
    return (v == 4'd0) ? 4'd9 : v - 4'd1;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_counts(string req);
    chk({req, " pair"}, {q_hi, q_lo}, m_pair);
    chk({req, " decade"}, q_dec, m_dec);
  endtask

  task automatic op_up(int w);
    @(negedge clk) inc = 1'b0;
    wait_n(4);
    chk("R7 ovf low at top", ovf_lo, (m_pair[3:0] == 4'hF) ? 0 : 1);
    chk("R7 decade ovf", ovf_dc, (m_dec == 4'd9) ? 0 : 1);
    wait_n(w);
    inc = 1'b1;
    m_pair = m_pair + 8'd1;
    m_dec = dec_up(m_dec);
    wait_n(10);
    check_counts("R2/R10 up");
  endtask

  task automatic op_dn(int w);
    @(negedge clk) dec = 1'b0;
    wait_n(4);
    chk("R8 unf low at zero", unf_lo, (m_pair[3:0] == 4'h0) ? 0 : 1);
    chk("R8 decade unf", unf_dc, (m_dec == 4'd0) ? 0 : 1);
    wait_n(w);
    dec = 1'b1;
    m_pair = m_pair - 8'd1;
    m_dec = dec_dn(m_dec);
    wait_n(10);
    check_counts("R3/R10 down");
  endtask

  task automatic op_both(int w);
    @(negedge clk) begin inc = 1'b0; dec = 1'b0; end
    wait_n(w + 3);
    inc = 1'b1; dec = 1'b1;
    // R4: low stage holds; the upper stage still sees the lower stage's wrap pulse
    if (m_pair[3:0] == 4'hF) m_pair[7:4] = m_pair[7:4] + 4'd1;
    else if (m_pair[3:0] == 4'h0) m_pair[7:4] = m_pair[7:4] - 4'd1;
    wait_n(10);
    check_counts("R4 both");
  endtask

  task automatic op_load(logic [3:0] lo, logic [3:0] hi);
    @(negedge clk) begin pre_n = 1'b0; d_lo = lo; d_hi = hi; end
    m_pair = {hi, lo};
    m_dec = lo;
    wait_n(6);
    check_counts("R5 preset");
    inc = 1'b0;
    wait_n(4);
    inc = 1'b1;
    wait_n(8);
    check_counts("R5 edges ignored");
    pre_n = 1'b1;
    wait_n(6);
    check_counts("R5 after release");
  endtask

  task automatic op_clear();
    @(negedge clk) begin zero = 1'b1; pre_n = 1'b0; d_lo = 4'd5; d_hi = 4'd7; end
    wait_n(3);
    dec = 1'b0;
    wait_n(3);
    dec = 1'b1;
    wait_n(6);
    m_pair = '0;
    m_dec = '0;
    check_counts("R6 clear priority");
    zero = 1'b0; pre_n = 1'b1; d_lo = '0; d_hi = '0;
    wait_n(6);
    check_counts("R6 after release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog R1..: run did not finish actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 reset count", q_lo, 0);
    chk("R1 reset ovf_n", ovf_lo, 1);
    chk("R1 reset unf_n", unf_lo, 1);

    // R11 latency: count changes exactly SYNC_STAGES+1 edges after the input edge
    @(negedge clk) inc = 1'b0;
    wait_n(4);
    @(negedge clk) inc = 1'b1;
    wait_n(2);
    chk("R11 not before 3 edges", q_lo, 0);
    wait_n(1);
    chk("R11 at 3 edges", q_lo, 1);
    m_pair = 8'd1; m_dec = 4'd1;
    wait_n(6);

    op_load(4'hF, 4'h0); op_up(3);
    chk("R10 carry into upper", q_hi, 1);
    op_load(4'h0, 4'h1); op_dn(3);
    chk("R10 borrow from upper", q_hi, 0);
    op_load(4'hF, 4'hF); op_up(2);
    chk("R2 binary wrap", q_lo, 0);
    op_load(4'h0, 4'h0); op_dn(2);
    chk("R3 binary wrap", q_lo, 15);
    op_load(4'd9, 4'd0); op_up(1);
    chk("R9 decade 9 up", q_dec, 0);
    op_dn(1);
    chk("R9 decade 0 down", q_dec, 9);
    op_load(4'd12, 4'd3); op_up(1);
    chk("R9 decade 12 up", q_dec, 0);
    op_load(4'd12, 4'd3); op_dn(1);
    chk("R9 decade 12 down", q_dec, 11);
    op_both(3);
    op_clear();

    for (int k = 0; k < 300; k++) begin
      int unsigned pick, w;
      pick = $urandom_range(0, 19);
      w = $urandom_range(1, 4);
      if (pick < 8) op_up(w);
      else if (pick < 16) op_dn(w);
      else if (pick < 17) op_both(w);
      else if (pick < 19) op_load(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      else op_clear();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule